// File: doc/BRIEF.md
# Reset and Start Sequencer

This block owns the reset and bring-up sequence of a cell-switch controller. An asynchronous reset request enters through a synchronizer. A request counts only once it has been seen high on `QUAL_CYCLES` consecutive clock edges (default eight). Once the request is qualified and then released, the block runs a fixed initialization window of `INIT_CYCLES` clocks (default 8191). That window stands in for clearing internal memories. At the end of the window the block raises a status-acknowledge bit.

The reset output toward downstream logic is a separate, second stage. It rises within two clock edges of the request and stays high after initialization has finished. It is released only when the call-setup controller pulses the start command while the status bit is already set. Short request pulses never restart the sequence, so a glitch on the reset line cannot silently wipe a running switch. In the RUN state the reset output does still follow the synchronized request level for the length of the pulse. The block has no stream interface: every pin is a plain level or a single-cycle strobe sampled on the rising clock edge.

Top module: `reset_start_seq`

## Requirements
- R1: A request is qualified when `rst_req_i` has been sampled high on `QUAL_CYCLES` (8) consecutive rising edges. A run of 7 does not qualify.
- R2: With `SYNC_STAGES` = 2, `rst_out_o` is high after the second rising edge that samples `rst_req_i` high. It is not yet high after the first such edge.
- R3: After a qualified request is released, `init_busy_o` stays high for exactly `INIT_CYCLES` cycles, starting on the 3rd rising edge that samples the request low. `init_ack_o` rises on the (`INIT_CYCLES`+3)th such edge.
- R4: While `init_ack_o` is high and the state is waiting for start, `rst_out_o` stays high. A `start_cmd_i` pulse sampled in that state drives `rst_out_o` low after that edge, provided the request input is low.
- R5: A `start_cmd_i` pulse sampled while `init_ack_o` is low is ignored. This includes the last initialization cycle: `rst_out_o` is still high after `init_ack_o` rises.
- R6: A request shorter than `QUAL_CYCLES` leaves `init_ack_o` and the initialization timing unchanged. In RUN, `rst_out_o` goes high for the pulse only and returns low two edges after the request is sampled low, with no new start command.
- R7: A qualified request during initialization aborts the count. A new full window starts from the new release.
- R8: On the edge after qualification completes, `init_ack_o` and `init_busy_o` are both low and `rst_out_o` is high, whatever the prior state.
- R9: Qualification wins over a start command or initialization completion that falls in the same cycle. The sequence restarts and the start is lost.
- R10: `init_ack_o` and `init_busy_o` are never high together. `init_busy_o` is low in the cycle between qualification and initialization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_req_i | input | 1 | Asynchronous reset request, active high |
| start_cmd_i | input | 1 | Single-cycle start command from call-setup control |
| rst_out_o | output | 1 | Reset toward downstream logic, active high |
| init_ack_o | output | 1 | Status acknowledge: initialization complete |
| init_busy_o | output | 1 | Initialization window in progress |

## Verification
Two collisions can land in the same cycle: a request finishing its qualification while a start command is sampled, and a qualification finishing in the last cycle of the initialization window. The bench times an 8-edge request so that its qualifying cycle coincides exactly with the strobe in one case and with the terminal count in the other. In both cases it checks on the following edge that the status bit is low, that the reset output is still high, and that a later full window has to pass before status returns. A sweep of request lengths 1 to 8 in RUN separates ignored pulses from the first qualifying one.

// File: rtl/rss_pkg.sv
package rss_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_QUALIFY    = 3'd1,
    ST_HOLD       = 3'd2,
    ST_INIT       = 3'd3,
    ST_WAIT_START = 3'd4,
    ST_RUN        = 3'd5
  } seq_state_e;

endpackage

// File: rtl/rss_sync.sv
// Multi-flop synchronizer for the asynchronous reset request.
module rss_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) chain_q[0] <= d_i;
    end else begin : g_many
      always_ff @(posedge clk) chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rss_qualify.sv
// Counts consecutive high cycles of the synchronized request; pulses
// hit_o exactly once per qualifying run.
module rss_qualify #(
  parameter int QUAL_CYCLES = 8
) (
  input  logic clk,
  input  logic lvl_i,
  output logic hit_o
);

  localparam int QW = $clog2(QUAL_CYCLES + 1);

  logic [QW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!lvl_i)
      run_q <= '0;
    else if (run_q != QW'(QUAL_CYCLES))
      run_q <= run_q + 1'b1;
  end

  assign hit_o = lvl_i && (run_q == QW'(QUAL_CYCLES - 1));

endmodule

// File: rtl/rss_init_ctr.sv
// Initialization window counter; runs while run_i, clears otherwise.
module rss_init_ctr #(
  parameter int INIT_CYCLES = 8191
) (
  input  logic clk,
  input  logic run_i,
  output logic last_o
);

  localparam int CW = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (run_i)
      cnt_q <= cnt_q + 1'b1;
    else
      cnt_q <= '0;
  end

  assign last_o = run_i && (cnt_q == CW'(INIT_CYCLES - 1));

endmodule

// File: rtl/rss_fsm.sv
// Sequencing state machine; a qualified request overrides every state.
module rss_fsm
  import rss_pkg::*;
(
  input  logic       clk,
  input  logic       req_i,
  input  logic       qual_hit_i,
  input  logic       init_last_i,
  input  logic       start_i,
  output seq_state_e state_o
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (qual_hit_i) begin
      state_d = ST_HOLD;
    end else begin
      case (state_q)
        ST_IDLE:       if (req_i)       state_d = ST_QUALIFY;
        ST_QUALIFY:    if (!req_i)      state_d = ST_IDLE;
        ST_HOLD:       if (!req_i)      state_d = ST_INIT;
        ST_INIT:       if (init_last_i) state_d = ST_WAIT_START;
        ST_WAIT_START: if (start_i)     state_d = ST_RUN;
        ST_RUN:                         state_d = ST_RUN;
        default:                        state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) state_q <= state_d;

  assign state_o = state_q;

endmodule

// File: rtl/reset_start_seq.sv
module reset_start_seq
  import rss_pkg::*;
#(
  parameter int QUAL_CYCLES = 8,
  parameter int INIT_CYCLES = 8191,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_req_i,
  input  logic start_cmd_i,
  output logic rst_out_o,
  output logic init_ack_o,
  output logic init_busy_o
);

  logic       req_sync;
  logic       qual_hit;
  logic       init_last;
  seq_state_e state;

  rss_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d_i (rst_req_i),
    .q_o (req_sync)
  );

  rss_qualify #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk   (clk),
    .lvl_i (req_sync),
    .hit_o (qual_hit)
  );

  rss_init_ctr #(.INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk    (clk),
    .run_i  (state == ST_INIT),
    .last_o (init_last)
  );

  rss_fsm u_fsm (
    .clk         (clk),
    .req_i       (req_sync),
    .qual_hit_i  (qual_hit),
    .init_last_i (init_last),
    .start_i     (start_cmd_i),
    .state_o     (state)
  );

  // Forward the request level at once; release only from RUN.
  assign rst_out_o   = (state != ST_RUN) || req_sync;
  assign init_ack_o  = (state == ST_WAIT_START) || (state == ST_RUN);
  assign init_busy_o = (state == ST_INIT);

endmodule

// File: rtl/reset_start_seq_chk.sv
module reset_start_seq_chk
  import rss_pkg::*;
#(
  parameter int INIT_CYCLES = 8191,
  parameter int SYNC_STAGES = 2
) (
  input logic       clk,
  input logic       rst_req_i,
  input logic       start_cmd_i,
  input logic       rst_out_o,
  input logic       init_ack_o,
  input logic       init_busy_o,
  input logic       qual_hit,
  input seq_state_e state
);

  localparam int RW = $clog2(INIT_CYCLES + 2);

  logic          armed;
  logic [RW-1:0] busy_run;

  always_ff @(posedge clk) begin
    if (state == ST_HOLD) armed <= 1'b1;
    busy_run <= init_busy_o ? busy_run + 1'b1 : '0;
  end

  generate
    if (SYNC_STAGES == 2) begin : g_s2
      p_out_follows_req_r2: assert property (@(posedge clk) disable iff (!armed)
        $past(rst_req_i, 2) |-> rst_out_o);
    end else begin : g_s1
      p_out_follows_req_r2: assert property (@(posedge clk) disable iff (!armed)
        $past(rst_req_i, 1) |-> rst_out_o);
    end
  endgenerate

  p_busy_len_r3: assert property (@(posedge clk) disable iff (!armed)
    $rose(init_ack_o) |-> (busy_run == RW'(INIT_CYCLES)));

  p_hold_until_start_r4: assert property (@(posedge clk) disable iff (!armed)
    (state == ST_WAIT_START && !start_cmd_i) |=> rst_out_o);

  p_start_release_r4: assert property (@(posedge clk) disable iff (!armed)
    (state == ST_WAIT_START && start_cmd_i && !qual_hit) |=> (state == ST_RUN));

  p_early_start_r5: assert property (@(posedge clk) disable iff (!armed)
    (!init_ack_o && start_cmd_i) |=> rst_out_o);

  p_ack_sticky_r6: assert property (@(posedge clk) disable iff (!armed)
    (init_ack_o && !qual_hit) |=> init_ack_o);

  p_qual_clears_r8: assert property (@(posedge clk) disable iff (!armed)
    qual_hit |=> (!init_ack_o && !init_busy_o && rst_out_o));

  p_ack_busy_excl_r10: assert property (@(posedge clk) disable iff (!armed)
    !(init_ack_o && init_busy_o));

endmodule

bind reset_start_seq reset_start_seq_chk #(
  .INIT_CYCLES (INIT_CYCLES),
  .SYNC_STAGES (SYNC_STAGES)
) u_chk (
  .clk         (clk),
  .rst_req_i   (rst_req_i),
  .start_cmd_i (start_cmd_i),
  .rst_out_o   (rst_out_o),
  .init_ack_o  (init_ack_o),
  .init_busy_o (init_busy_o),
  .qual_hit    (qual_hit),
  .state       (state)
);

// File: tb/tb_reset_start_seq.sv
`timescale 1ns/1ps
module tb_reset_start_seq;

  localparam int N = 8191;   // initialization window (R3)
  localparam int Q = 8;      // qualification length (R1)

  logic clk = 1'b0;
  logic rst_req = 1'b0;
  logic start_cmd = 1'b0;
  logic rst_out, ack, busy;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  reset_start_seq dut (
    .clk         (clk),
    .rst_req_i   (rst_req),
    .start_cmd_i (start_cmd),
    .rst_out_o   (rst_out),
    .init_ack_o  (ack),
    .init_busy_o (busy)
  );

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(3);

    // Power-on request of exactly Q edges, then the initialization window
    rst_req = 1'b1; step(Q); rst_req = 1'b0;           // t = 0
    step(2);
    chk("R10 busy low in hold", busy, 1'b0);
    chk("R2 rst_out high", rst_out, 1'b1);
    chk("R1 ack low after request", ack, 1'b0);
    step(1);                                            // t = 3
    chk("R3 busy starts", busy, 1'b1);
    step(97);                                           // t = 100
    rst_req = 1'b1; step(3); rst_req = 1'b0;            // short pulse, t = 103
    step(N - 101);                                      // t = N+2, last init cycle
    chk("R6 ack unchanged by short pulse", ack, 1'b0);
    chk("R3 busy in last cycle", busy, 1'b1);
    start_cmd = 1'b1; step(1); start_cmd = 1'b0;        // t = N+3
    chk("R3 ack rises on time", ack, 1'b1);
    chk("R3 busy ends", busy, 1'b0);
    chk("R5 early start ignored", rst_out, 1'b1);

    // Waiting for start, then release
    step(5);
    chk("R4 rst_out held until start", rst_out, 1'b1);
    start_cmd = 1'b1; step(1); start_cmd = 1'b0;
    chk("R4 start releases rst_out", rst_out, 1'b0);
    chk("R4 ack stays", ack, 1'b1);

    // Sweep of short requests in RUN
    for (int len = 1; len < Q; len++) begin
      rst_req = 1'b1;
      for (int k = 1; k <= len + 2; k++) begin
        if (k == len + 1) rst_req = 1'b0;
        step(1);
        if (k == 1) chk("R2 not before second edge", rst_out, 1'b0);
        if (k == 2) chk("R2 rst_out follows request", rst_out, 1'b1);
      end
      chk("R6 rst_out returns low", rst_out, 1'b0);
      chk("R6 ack kept after short pulse", ack, 1'b1);
      step(2);
    end

    // First qualifying length in RUN
    rst_req = 1'b1; step(Q);
    chk("R1 ack before qualification", ack, 1'b1);
    rst_req = 1'b0; step(1);
    chk("R1 ack in qualifying cycle", ack, 1'b1);
    step(1);                                            // t = 2
    chk("R8 ack cleared", ack, 1'b0);
    chk("R8 rst_out high", rst_out, 1'b1);
    chk("R8 busy low", busy, 1'b0);

    // Qualified request in the middle of initialization
    step(198);                                          // t = 200
    rst_req = 1'b1; step(Q); rst_req = 1'b0;            // new release, t' = 0
    step(N + 3 - 208);
    chk("R7 old window aborted", ack, 1'b0);
    chk("R7 counting anew", busy, 1'b1);

    // Qualification lands on the last initialization cycle
    step(198);                                          // t' = N-7
    rst_req = 1'b1; step(Q); rst_req = 1'b0;            // t' = N+1
    step(1);                                            // t' = N+2
    chk("R9 still last init cycle", busy, 1'b1);
    chk("R9 ack low in collision cycle", ack, 1'b0);
    step(1);
    chk("R9 qualification wins over completion", ack, 1'b0);
    chk("R9 busy low in hold", busy, 1'b0);
    step(N);
    chk("R3 ack low one edge early", ack, 1'b0);
    step(1);
    chk("R3 ack after restarted window", ack, 1'b1);

    // Qualification coincides with start command
    step(3);
    rst_req = 1'b1; step(Q); rst_req = 1'b0;
    step(1);
    chk("R1 ack still set in qualifying cycle", ack, 1'b1);
    start_cmd = 1'b1; step(1); start_cmd = 1'b0;        // t = 2
    chk("R9 qualification wins over start", ack, 1'b0);
    chk("R9 rst_out held", rst_out, 1'b1);
    step(N);
    chk("R3 ack low before window end", ack, 1'b0);
    step(1);
    chk("R3 ack after window", ack, 1'b1);
    step(4);
    chk("R9 lost start not remembered", rst_out, 1'b1);
    start_cmd = 1'b1; step(1); start_cmd = 1'b0;
    chk("R4 fresh start releases", rst_out, 1'b0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule